// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset causes into one chip-level reset: a power-on event, a brown-out event, an external master-clear level and a watchdog time-out. It keeps the chip reset asserted until the start-up delays that the cause calls for have run. It also records which cause occurred, so that software can find out after the reset why it happened. The analog detectors, the oscillators and the watchdog counter are outside the block. The block only sees their results, as single-cycle event pulses and a master-clear level, all synchronous to `clk_i`.

There are two delay stages, and they run one after the other. The first is a power-up delay of 2^CNT_W ticks of the internal RC clock (`rc_tick_i`). This stage is used only after a power-on or brown-out event, and only if `pwrt_en_i` is set. The second is an oscillator settling delay of 2^CNT_W cycles of the main clock. It always follows the power-up delay, and it also runs on its own when the part wakes from sleep in crystal or low-frequency mode. When no power-up delay is running, the RC tick is passed on to the watchdog.

While the chip reset is high, the core must keep every pin as a high-impedance input and hold its phase counter at the first phase. `core_hold_o` carries this request. It also covers a wake-up settling delay, during which the chip reset itself stays low.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_ni` is low, `chip_rst_o` and `core_hold_o` are 1, `to_o` and `pd_o` are 1, `por_n_o` is 0 and `bor_n_o` is 1. After `rst_ni` rises with `mclr_i` low, `chip_rst_o` falls at the first clock edge.
- R2: A `por_i` or `bor_i` pulse with `pwrt_en_i`=1 sets `chip_rst_o` from the next edge. The reset then stays high for 2^CNT_W `rc_tick_i` pulses, followed by 2^CNT_W clock cycles. It falls on the edge after the final settling count.
- R3: A `por_i` or `bor_i` pulse with `pwrt_en_i`=0 runs no delay. With `mclr_i` low, it gives a reset that lasts exactly one cycle.
- R4: A `wdt_to_i` pulse or a high `mclr_i` sets `chip_rst_o` from the next edge, and neither starts a delay. `chip_rst_o` falls at the first edge that samples `mclr_i` low.
- R5: If `mclr_i` goes high during either delay stage, the power-up count restarts from zero once `mclr_i` is released. The full sequence of both stages then runs again.
- R6: A `wake_i` pulse while idle makes `core_hold_o` high for 2^CNT_W cycles, provided `osc_mode_i` is 0 (crystal) or 1 (low-frequency). `chip_rst_o` stays 0 throughout. For modes 2 (external clock) and 3 (RC), the pulse has no effect.
- R7: `wdt_tick_o` follows `rc_tick_i`, except while the power-up delay is counting, when it is 0.
- R8: Power-on sets `to_o`=1 and `pd_o`=1 and clears `por_n_o`. A watchdog time-out clears `to_o`. Brown-out clears `bor_n_o`. Master-clear changes no flag.
- R9: A `flag_ack_i` pulse sets `por_n_o` and `bor_n_o` to 1. If a power-on or brown-out event arrives in the same cycle, that event wins for the flag it writes.
- R10: A power-on or brown-out event always restarts the sequence from the beginning, whatever state the block is in.
- R11: `chip_rst_o`=1 always implies `core_hold_o`=1. A wake-up delay is ended by a watchdog time-out or a master-clear, which enter the reset path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_i | input | 1 | Power-on event pulse |
| bor_i | input | 1 | Brown-out event pulse |
| mclr_i | input | 1 | External master-clear level, active high |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| pwrt_en_i | input | 1 | Enables the power-up delay |
| wake_i | input | 1 | Wake-from-sleep pulse |
| osc_mode_i | input | 2 | 0 crystal, 1 low-frequency, 2 external clock, 3 RC |
| rc_tick_i | input | 1 | One-cycle tick of the internal RC clock |
| flag_ack_i | input | 1 | Re-arms the power-on and brown-out flags |
| chip_rst_o | output | 1 | Chip reset |
| core_hold_o | output | 1 | Pins to input and phase counter held at first phase |
| wdt_tick_o | output | 1 | RC tick passed on to the watchdog |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |
| por_n_o | output | 1 | Power-on flag, 0 after a power-on |
| bor_n_o | output | 1 | Brown-out flag, 0 after a brown-out |

## Verification
The bench targets the following corner cases:

- **Master-clear in the middle of each stage.** A design that resumed the count instead of restarting it would drop the reset hundreds of cycles too early.
- **Power-on with the power-up delay disabled.** A design that still armed the delay would hold the reset for thousands of cycles instead of one.
- **Wake-up pulses in every oscillator mode.** A wrong mode decode would either hold the core after an external-clock wake or skip the crystal settling time.
- **Flag acknowledge in the same cycle as a power-on.** A design with the wrong priority would report a power-on flag of 1 after a power-on.
- **RC tick during the power-up delay.** A design that did not gate it would feed the watchdog while the delay owns the RC clock.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_PWRT,
    SEQ_OST,
    SEQ_WAKE
  } seq_state_e;

  localparam logic [1:0] OSC_XTAL = 2'd0;
  localparam logic [1:0] OSC_LOWF = 2'd1;
  localparam logic [1:0] OSC_EXT  = 2'd2;
  localparam logic [1:0] OSC_RC   = 2'd3;

  localparam int unsigned N_TIMERS = 2;
  localparam int unsigned T_PWRT   = 0;
  localparam int unsigned T_OST    = 1;

  typedef struct packed {
    logic por;
    logic bor;
    logic wdt;
    logic mclr;
  } cause_t;

  function automatic logic osc_needs_settle(input logic [1:0] mode);
    return (mode == OSC_XTAL) || (mode == OSC_LOWF);
  endfunction

endpackage

// File: rtl/rst_delay_timer.sv
module rst_delay_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rst_status_flags.sv
module rst_status_flags
  import rst_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cause_t evt_i,
  input  logic   ack_i,
  output logic   to_o,
  output logic   pd_o,
  output logic   por_n_o,
  output logic   bor_n_o
);

  logic to_q, pd_q, por_n_q, bor_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q    <= 1'b1;
      pd_q    <= 1'b1;
      por_n_q <= 1'b0;
      bor_n_q <= 1'b1;
    end else begin
      // power-on owns to/pd; watchdog only lowers to
      if (evt_i.por) begin
        to_q <= 1'b1;
        pd_q <= 1'b1;
      end else if (evt_i.wdt) begin
        to_q <= 1'b0;
      end
      if (evt_i.por)  por_n_q <= 1'b0;
      else if (ack_i) por_n_q <= 1'b1;
      if (evt_i.bor)  bor_n_q <= 1'b0;
      else if (ack_i) bor_n_q <= 1'b1;
    end
  end

  assign to_o    = to_q;
  assign pd_o    = pd_q;
  assign por_n_o = por_n_q;
  assign bor_n_o = bor_n_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cause_t     evt_i,
  input  logic       pwrt_en_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       rc_tick_i,
  input  logic       pwrt_last_i,
  input  logic       ost_last_i,
  output logic       pwrt_clr_o,
  output logic       pwrt_step_o,
  output logic       ost_clr_o,
  output logic       ost_step_o,
  output logic       chip_rst_o,
  output logic       core_hold_o,
  output logic       pwrt_busy_o
);

  seq_state_e state_q, state_d;
  logic       rst_q, rst_d;
  logic       restart;

  always_comb begin
    state_d = state_q;
    rst_d   = rst_q;
    restart = 1'b0;
    if (evt_i.por || evt_i.bor) begin
      rst_d   = 1'b1;
      restart = 1'b1;
      state_d = pwrt_en_i ? SEQ_PWRT : SEQ_WAIT;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (evt_i.wdt || evt_i.mclr) begin
            state_d = SEQ_WAIT;
            rst_d   = 1'b1;
          end else if (wake_i && osc_needs_settle(osc_mode_i)) begin
            state_d = SEQ_WAKE;
          end
        end
        SEQ_WAIT: begin
          if (!evt_i.mclr) begin
            state_d = SEQ_IDLE;
            rst_d   = 1'b0;
          end
        end
        SEQ_PWRT: begin
          // master-clear pins the power-up count at zero
          if (evt_i.mclr) restart = 1'b1;
          else if (rc_tick_i && pwrt_last_i) state_d = SEQ_OST;
        end
        SEQ_OST: begin
          if (evt_i.mclr) begin
            state_d = SEQ_PWRT;
          end else if (ost_last_i) begin
            state_d = SEQ_IDLE;
            rst_d   = 1'b0;
          end
        end
        SEQ_WAKE: begin
          if (evt_i.wdt || evt_i.mclr) begin
            state_d = SEQ_WAIT;
            rst_d   = 1'b1;
          end else if (ost_last_i) begin
            state_d = SEQ_IDLE;
          end
        end
        default: begin
          state_d = SEQ_WAIT;
          rst_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_WAIT;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  logic settling;
  assign settling    = (state_q == SEQ_OST) || (state_q == SEQ_WAKE);
  assign pwrt_busy_o = (state_q == SEQ_PWRT);
  assign pwrt_clr_o  = !pwrt_busy_o || restart;
  assign pwrt_step_o = pwrt_busy_o && rc_tick_i;
  assign ost_clr_o   = !settling;
  assign ost_step_o  = settling;
  assign chip_rst_o  = rst_q;
  assign core_hold_o = rst_q || (state_q == SEQ_WAKE);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       mclr_i,
  input  logic       wdt_to_i,
  input  logic       pwrt_en_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       rc_tick_i,
  input  logic       flag_ack_i,
  output logic       chip_rst_o,
  output logic       core_hold_o,
  output logic       wdt_tick_o,
  output logic       to_o,
  output logic       pd_o,
  output logic       por_n_o,
  output logic       bor_n_o
);

  cause_t                evt;
  logic [N_TIMERS-1:0]   t_clr, t_step, t_last;
  logic                  pwrt_busy;

  assign evt = '{por: por_i, bor: bor_i, wdt: wdt_to_i, mclr: mclr_i};

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    rst_delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (t_clr[g]),
      .step_i (t_step[g]),
      .last_o (t_last[g])
    );
  end

  rst_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .pwrt_en_i   (pwrt_en_i),
    .wake_i      (wake_i),
    .osc_mode_i  (osc_mode_i),
    .rc_tick_i   (rc_tick_i),
    .pwrt_last_i (t_last[T_PWRT]),
    .ost_last_i  (t_last[T_OST]),
    .pwrt_clr_o  (t_clr[T_PWRT]),
    .pwrt_step_o (t_step[T_PWRT]),
    .ost_clr_o   (t_clr[T_OST]),
    .ost_step_o  (t_step[T_OST]),
    .chip_rst_o  (chip_rst_o),
    .core_hold_o (core_hold_o),
    .pwrt_busy_o (pwrt_busy)
  );

  rst_status_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .ack_i   (flag_ack_i),
    .to_o    (to_o),
    .pd_o    (pd_o),
    .por_n_o (por_n_o),
    .bor_n_o (bor_n_o)
  );

  // RC clock belongs to the power-up delay while it counts
  assign wdt_tick_o = rc_tick_i && !pwrt_busy;

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       bor_i,
  input logic       mclr_i,
  input logic       wdt_to_i,
  input logic       wake_i,
  input logic [1:0] osc_mode_i,
  input logic       rc_tick_i,
  input logic       flag_ack_i,
  input logic       chip_rst_o,
  input logic       core_hold_o,
  input logic       wdt_tick_o,
  input logic       to_o,
  input logic       pd_o,
  input logic       por_n_o,
  input logic       bor_n_o
);

  assert_event_sets_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i) |=> chip_rst_o);

  assert_mclr_wdt_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclr_i || wdt_to_i) |=> chip_rst_o);

  assert_wake_mode_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_hold_o && wake_i && osc_mode_i[1] && !por_i && !bor_i && !wdt_to_i && !mclr_i)
      |=> !core_hold_o);

  assert_tick_passes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_rst_o |-> (wdt_tick_o == rc_tick_i));

  assert_por_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (to_o && pd_o && !por_n_o));

  assert_wdt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_to_i && !por_i) |=> !to_o);

  assert_ack_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_ack_i && !por_i && !bor_i) |=> (por_n_o && bor_n_o));

  assert_hold_covers_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> core_hold_o);

endmodule

bind reset_sequencer rst_seq_checker u_chk (.*);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;

  localparam int unsigned CNT_W = 10;
  localparam int LIM = 1 << CNT_W;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, bor = 0, mclr = 0, wdt = 0, pwrt_en = 1, wake = 0, rc_tick = 0, ack = 0;
  logic [1:0] mode = 2'd0;
  logic chip_rst, core_hold, wdt_tick, to_f, pd_f, porn_f, born_f;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  reset_sequencer #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .bor_i(bor), .mclr_i(mclr),
    .wdt_to_i(wdt), .pwrt_en_i(pwrt_en), .wake_i(wake), .osc_mode_i(mode),
    .rc_tick_i(rc_tick), .flag_ack_i(ack), .chip_rst_o(chip_rst),
    .core_hold_o(core_hold), .wdt_tick_o(wdt_tick), .to_o(to_f), .pd_o(pd_f),
    .por_n_o(porn_f), .bor_n_o(born_f)
  );

  // reference model: phase 0 idle, 1 held, 2 power-up, 3 settle, 4 wake
  int ph, rc_cnt, os_cnt;
  bit m_rst, m_to, m_pd, m_porn, m_born;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 1; rc_cnt = 0; os_cnt = 0; m_rst = 1;
      m_to = 1; m_pd = 1; m_porn = 0; m_born = 1;
    end else begin
      if (por) begin m_to = 1; m_pd = 1; m_porn = 0; end
      else begin
        if (wdt) m_to = 0;
        if (ack) m_porn = 1;
      end
      if (bor) m_born = 0; else if (ack) m_born = 1;
      if (por || bor) begin
        m_rst = 1; rc_cnt = 0; os_cnt = 0;
        ph = pwrt_en ? 2 : 1;
      end else if (ph == 0) begin
        if (wdt || mclr) begin ph = 1; m_rst = 1; end
        else if (wake && mode < 2) begin ph = 4; os_cnt = 0; end
      end else if (ph == 1) begin
        if (!mclr) begin ph = 0; m_rst = 0; end
      end else if (ph == 2) begin
        if (mclr) rc_cnt = 0;
        else if (rc_tick) begin
          rc_cnt++;
          if (rc_cnt == LIM) begin ph = 3; os_cnt = 0; end
        end
      end else begin
        if ((ph == 3 && mclr) ) begin ph = 2; rc_cnt = 0; end
        else if (ph == 4 && (wdt || mclr)) begin ph = 1; m_rst = 1; end
        else begin
          os_cnt++;
          if (os_cnt == LIM) begin
            if (ph == 3) m_rst = 0;
            ph = 0;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: sample at negedge, compare with model, then drive rc tick
  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > MAX_CYC) begin
      chk(0, "watchdog expired", cyc, MAX_CYC);
      finish_run();
    end
    if (rst_n) begin
      chk(chip_rst == m_rst, "R2 chip_rst vs model", chip_rst, m_rst);
      chk(core_hold == (m_rst || ph == 4), "R6 core_hold vs model", core_hold, m_rst || ph == 4);
      chk(wdt_tick == (rc_tick && ph != 2), "R7 wdt_tick vs model", wdt_tick, rc_tick && ph != 2);
      chk({to_f, pd_f, porn_f, born_f} == {m_to, m_pd, m_porn, m_born}, "R8 flags vs model",
          {to_f, pd_f, porn_f, born_f}, {m_to, m_pd, m_porn, m_born});
    end
    rc_tick = cyc[0];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic settle_len(input string tag, input int lo, input int hi);
    int n = 0;
    while (chip_rst && n < 10000) begin step(); n++; end
    chk(n >= lo && n <= hi, tag, n, lo);
  endtask

  initial begin
    run(3);
    chk(chip_rst && core_hold && to_f && pd_f && !porn_f && born_f, "R1 reset values",
        {chip_rst, core_hold, to_f, pd_f, porn_f, born_f}, 6'b111101);
    rst_n = 1'b1;
    step();
    chk(!chip_rst, "R1 release after reset", chip_rst, 0);
    run(3);

    // full power-on sequence
    por = 1; step(); por = 0;
    chk(chip_rst && !porn_f, "R8 por sets rst and flag", chip_rst, 1);
    run(2 * LIM + LIM - 40);
    chk(chip_rst, "R2 still held near end", chip_rst, 1);
    settle_len("R2 remaining hold", 1, 50);
    chk(!chip_rst, "R2 released", chip_rst, 0);
    run(5);

    // ack, then brown-out without power-up delay
    ack = 1; step(); ack = 0;
    chk(porn_f && born_f, "R9 ack re-arms flags", {porn_f, born_f}, 3);
    pwrt_en = 0; bor = 1; step(); bor = 0;
    chk(chip_rst && !born_f, "R3 bor no-delay reset", chip_rst, 1);
    step();
    chk(!chip_rst, "R3 one-cycle reset", chip_rst, 0);
    pwrt_en = 1;

    // watchdog from idle
    wdt = 1; step(); wdt = 0;
    chk(chip_rst && !to_f, "R4 wdt reset clears to", {chip_rst, to_f}, 2);
    step();
    chk(!chip_rst, "R4 wdt released", chip_rst, 0);

    // master-clear held
    mclr = 1; run(6);
    chk(chip_rst && !to_f && born_f == 0, "R8 mclr keeps flags", {to_f, born_f}, 0);
    mclr = 0; step();
    chk(!chip_rst, "R4 release after mclr low", chip_rst, 0);

    // master-clear during power-up stage restarts everything
    por = 1; step(); por = 0;
    run(600);
    mclr = 1; run(8); mclr = 0;
    settle_len("R5 restart from power-up stage", 3 * LIM - 2, 3 * LIM + 4);

    // master-clear during settling stage
    por = 1; step(); por = 0;
    run(2 * LIM + 300);
    chk(chip_rst, "R5 inside settle stage", chip_rst, 1);
    mclr = 1; run(4); mclr = 0;
    settle_len("R5 restart from settle stage", 3 * LIM - 2, 3 * LIM + 4);

    // power-on during settling restarts (with ack same cycle)
    por = 1; step(); por = 0;
    run(2 * LIM + 100);
    por = 1; ack = 1; step(); por = 0; ack = 0;
    chk(!porn_f && born_f, "R9 por beats ack", {porn_f, born_f}, 1);
    settle_len("R10 por restart", 3 * LIM - 2, 3 * LIM + 4);

    // wake-ups per mode
    for (int m = 0; m < 4; m++) begin
      run(3);
      mode = 2'(m); wake = 1; step(); wake = 0;
      chk(core_hold == (m < 2) && !chip_rst, "R6 wake hold by mode", core_hold, m < 2);
      run(LIM + 2);
      chk(!core_hold, "R6 wake hold ended", core_hold, 0);
    end

    // watchdog cuts a wake delay
    mode = 2'd1; wake = 1; step(); wake = 0;
    run(20);
    wdt = 1; step(); wdt = 0;
    chk(chip_rst && core_hold, "R11 wdt ends wake", {chip_rst, core_hold}, 3);
    step();
    chk(!chip_rst && !core_hold, "R11 back to idle", {chip_rst, core_hold}, 0);

    // gated tick during power-up stage
    por = 1; step(); por = 0;
    run(10);
    chk(!wdt_tick, "R7 tick gated in power-up", wdt_tick, 0);
    settle_len("R2 second full sequence", 3 * LIM - 20, 3 * LIM + 4);

    run(5);
    finish_run();
  end

endmodule